// File: doc/BRIEF.md
# Single-Wire Link Frame Receiver

This block watches the input side of a single-wire serial link and rebuilds the bytes sent on it. A frame opens with three synchronisation pads. Each pad is a high phase followed by a low bit. After the last opening pad come the data bytes, and a single pad comes before every byte after the first. Each byte carries eight data bits, least significant first. The block times the bits with three durations, given in clock cycles on input ports: the pad length, the data-bit length and the acceptance length. It does not need an oversampled clock recovery. It finds the end of a frame by silence: no pad begins within one pad length after a byte.

Recovered bytes go out through a small buffer to an 8-bit AXI4-Stream master port, with TLAST set on the final byte of the frame. The link cannot be stalled. When the buffer is full, new bytes are dropped. The receiver listens only while it is enabled and the companion transmitter is not busy, so it never captures its own traffic. The transmitter can also arm it for exactly one acknowledgement byte, which is preceded by a single pad, even when the enable is low. A status output shows when a reception is under way. The transmitter uses that status to hold off.

Top module: `sw_link_rx`

## Requirements
- R1: After reset, `m_tvalid_o` and `rx_busy_o` are low.
- R2: A high level on `link_i` starts a reception only when `rx_en_i` is high and `tx_busy_i` is low, or when acknowledgement mode is armed. Otherwise the link is ignored and no beat appears.
- R3: A pad is valid when its high run lasts at least `accept_len_i` cycles and then falls low. A shorter high run cancels the reception. A frame begins only after three valid pads in a row.
- R4: Bit slots are `bit_len_i` cycles long. Slot 0 starts with the first low cycle after a pad. Each slot is sampled at cycle `bit_len_i/2` within the slot. Slot 0 must read low, and slots 1 to 8 carry data bits 0 to 7, least significant first. `bit_len_i` is at least 2.
- R5: The frame ends when `link_i` stays low for `pad_len_i` cycles after the last slot of a byte. The final byte then carries TLAST=1, and every other byte carries TLAST=0. A byte enters the buffer at the end of the next byte's last slot, or at the end of that silence.
- R6: A pad shorter than the acceptance length in the middle of a frame cancels the frame. The byte not yet buffered is dropped, and no TLAST beat is produced.
- R7: A one-cycle pulse on `start_ack_i` while the receiver is idle arms it for one acknowledgement byte, regardless of `rx_en_i` and `tx_busy_i`. That byte needs one pad and is buffered with TLAST=1 at the end of its last slot. The receiver is then disarmed.
- R8: `rx_busy_o` rises the cycle after the first high level is accepted. It falls the cycle after the frame ends, is cancelled, or its acknowledgement byte completes.
- R9: The buffer holds `DEPTH` beats (default 2, minimum 1) and keeps their order. A beat is visible on the port the cycle after it is written. A byte that arrives when the buffer holds `DEPTH` beats is discarded. A beat holds steady while TREADY is low.
- R10: `m_tkeep_o` is constant 1 and `m_tuser_o` is constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| link_i | input | 1 | Link input level, already conditioned |
| rx_en_i | input | 1 | Receive enable |
| tx_busy_i | input | 1 | Transmitter is sending |
| start_ack_i | input | 1 | Pulse that arms one acknowledgement byte |
| pad_len_i | input | CNT_W | Pad length in cycles, also the end-of-frame silence |
| bit_len_i | input | CNT_W | Data-bit length in cycles |
| accept_len_i | input | CNT_W | Minimum high run of a valid pad |
| m_tvalid_o | output | 1 | Stream valid |
| m_tready_i | input | 1 | Stream ready |
| m_tdata_o | output | 8 | Received byte |
| m_tlast_o | output | 1 | Final byte of the frame |
| m_tkeep_o | output | 1 | Byte qualifier, always 1 |
| m_tuser_o | output | USER_W | Sideband, always 0 |
| rx_busy_o | output | 1 | Reception in progress |

## Verification
Take F as the first low cycle after the pad that comes before a byte. That byte's last slot ends in cycle F+9·bit_len−1. The byte held before it is written in that cycle and appears on TVALID one cycle later. The final byte, or an acknowledgement byte, is written at F+9·bit_len+pad_len−1, or at F+9·bit_len−1 for an acknowledgement. `rx_busy_o` is high from one cycle after the first accepted high level up to and including the cycle that writes the last byte or cancels the frame.

The bench builds each waveform together with a list of expected write cycles taken from these offsets. It feeds that list into a queue-based buffer model and compares the stream outputs and the busy flag against the model at every falling edge.

// File: rtl/sw_link_rx_pkg.sv
package sw_link_rx_pkg;

    localparam int BYTE_W    = 8;
    localparam int SYNC_PADS = 3;
    localparam int PAD_W     = $clog2(SYNC_PADS + 1);
    localparam int SLOT_W    = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HIGH  = 3'd1,
        ST_BITS  = 3'd2,
        ST_GAP   = 3'd3,
        ST_AFTER = 3'd4
    } rx_state_e;

    typedef struct packed {
        logic              last;
        logic [BYTE_W-1:0] data;
    } beat_t;

endpackage

// File: rtl/sw_rx_framer.sv
module sw_rx_framer
    import sw_link_rx_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              link_i,
    input  logic              en_i,
    input  logic              tx_busy_i,
    input  logic              start_ack_i,
    input  logic [CNT_W-1:0]  pad_len_i,
    input  logic [CNT_W-1:0]  bit_len_i,
    input  logic [CNT_W-1:0]  accept_len_i,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_ack_o,
    output logic              frame_end_o,
    output logic              abort_o,
    output logic              busy_o,
    output logic              ack_armed_o
);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [SLOT_W-1:0] slot;
        logic [PAD_W-1:0]  pads;
        logic              synced;
        logic              ack;
        logic [BYTE_W-1:0] sh;
    } fr_t;

    fr_t q, d;

    logic             armed;
    logic             go_idle;
    logic [PAD_W-1:0] need;
    logic [PAD_W-1:0] pads_inc;
    logic [CNT_W-1:0] cnt_up;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] bit_last;
    logic [CNT_W-1:0] pad_last;

    always_comb begin
        d           = q;
        byte_vld_o  = 1'b0;
        byte_o      = q.sh;
        byte_ack_o  = 1'b0;
        frame_end_o = 1'b0;
        abort_o     = 1'b0;
        go_idle     = 1'b0;

        armed    = q.ack | start_ack_i | (en_i & ~tx_busy_i);
        need     = (q.synced | q.ack) ? PAD_W'(1) : PAD_W'(SYNC_PADS);
        pads_inc = q.pads + PAD_W'(1);
        cnt_up   = (&q.cnt) ? q.cnt : q.cnt + CNT_W'(1);
        half     = bit_len_i >> 1;
        bit_last = bit_len_i - CNT_W'(1);
        pad_last = pad_len_i - CNT_W'(1);

        unique case (q.st)
            ST_IDLE: begin
                if (start_ack_i) d.ack = 1'b1;
                if (link_i && armed) begin
                    d.st   = ST_HIGH;
                    d.cnt  = CNT_W'(1);
                    d.pads = '0;
                end
            end
            ST_HIGH: begin
                if (link_i) begin
                    d.cnt = cnt_up;
                end else if (q.cnt >= accept_len_i) begin
                    d.st   = ST_BITS;
                    d.cnt  = CNT_W'(1);
                    d.slot = '0;
                end else begin
                    abort_o = 1'b1;
                    go_idle = 1'b1;
                end
            end
            ST_BITS: begin
                d.cnt = cnt_up;
                if (q.cnt == half) begin
                    if (q.slot == '0) begin
                        if (link_i) begin
                            abort_o = 1'b1;
                            go_idle = 1'b1;
                        end else begin
                            d.pads = pads_inc;
                            if (pads_inc < need) begin
                                d.st  = ST_GAP;
                                d.cnt = '0;
                            end
                        end
                    end else begin
                        d.sh = {link_i, q.sh[BYTE_W-1:1]};
                    end
                end
                if (!go_idle && d.st == ST_BITS && q.cnt == bit_last) begin
                    d.cnt  = '0;
                    d.slot = q.slot + SLOT_W'(1);
                    if (q.slot == SLOT_W'(BYTE_W)) begin
                        byte_vld_o = 1'b1;
                        byte_o     = d.sh;
                        if (q.ack) begin
                            byte_ack_o = 1'b1;
                            go_idle    = 1'b1;
                        end else begin
                            d.st     = ST_AFTER;
                            d.pads   = '0;
                            d.synced = 1'b1;
                            d.slot   = '0;
                        end
                    end
                end
            end
            ST_GAP, ST_AFTER: begin
                if (link_i) begin
                    d.st  = ST_HIGH;
                    d.cnt = CNT_W'(1);
                end else if (q.cnt == pad_last) begin
                    go_idle = 1'b1;
                    if (q.st == ST_AFTER) frame_end_o = 1'b1;
                    else                  abort_o     = 1'b1;
                end else begin
                    d.cnt = cnt_up;
                end
            end
            default: go_idle = 1'b1;
        endcase

        if (go_idle) begin
            d.st     = ST_IDLE;
            d.cnt    = '0;
            d.slot   = '0;
            d.pads   = '0;
            d.synced = 1'b0;
            d.ack    = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign busy_o      = (q.st != ST_IDLE);
    assign ack_armed_o = q.ack;

endmodule

// File: rtl/sw_rx_tail.sv
module sw_rx_tail
    import sw_link_rx_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              byte_ack_i,
    input  logic              frame_end_i,
    input  logic              abort_i,
    output logic              push_o,
    output beat_t             beat_o
);

    typedef struct packed {
        logic              held;
        logic [BYTE_W-1:0] data;
    } tail_t;

    tail_t q, d;

    always_comb begin
        d      = q;
        push_o = 1'b0;
        beat_o = '{last: 1'b0, data: q.data};
        if (byte_vld_i) begin
            if (byte_ack_i) begin
                push_o = 1'b1;
                beat_o = '{last: 1'b1, data: byte_i};
            end else begin
                push_o = q.held;
                d.data = byte_i;
                d.held = 1'b1;
            end
        end else if (frame_end_i) begin
            push_o      = q.held;
            beat_o.last = 1'b1;
            d.held      = 1'b0;
        end else if (abort_i) begin
            d.held = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

endmodule

// File: rtl/sw_rx_fifo.sv
module sw_rx_fifo
    import sw_link_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  push_i,
    input  beat_t beat_i,
    input  logic  pop_i,
    output logic  valid_o,
    output beat_t beat_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    typedef struct packed {
        beat_t [DEPTH-1:0] mem;
        logic  [PTR_W-1:0] wr;
        logic  [PTR_W-1:0] rd;
        logic  [OCC_W-1:0] occ;
    } fifo_t;

    fifo_t q, d;
    logic  take, give;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        d    = q;
        take = push_i && (q.occ != OCC_W'(DEPTH));
        give = pop_i && (q.occ != '0);
        if (take) begin
            d.mem[q.wr] = beat_i;
            d.wr        = step(q.wr);
        end
        if (give) d.rd = step(q.rd);
        unique case ({take, give})
            2'b10:   d.occ = q.occ + OCC_W'(1);
            2'b01:   d.occ = q.occ - OCC_W'(1);
            default: d.occ = q.occ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign valid_o = (q.occ != '0);
    assign beat_o  = q.mem[q.rd];

endmodule

// File: rtl/sw_link_rx.sv
module sw_link_rx
    import sw_link_rx_pkg::*;
#(
    parameter int DEPTH  = 2,
    parameter int CNT_W  = 12,
    parameter int USER_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              link_i,
    input  logic              rx_en_i,
    input  logic              tx_busy_i,
    input  logic              start_ack_i,
    input  logic [CNT_W-1:0]  pad_len_i,
    input  logic [CNT_W-1:0]  bit_len_i,
    input  logic [CNT_W-1:0]  accept_len_i,
    output logic              m_tvalid_o,
    input  logic              m_tready_i,
    output logic [BYTE_W-1:0] m_tdata_o,
    output logic              m_tlast_o,
    output logic              m_tkeep_o,
    output logic [USER_W-1:0] m_tuser_o,
    output logic              rx_busy_o
);

    logic              byte_vld, byte_ack, frame_end, abort, push, ack_armed;
    logic [BYTE_W-1:0] byte_val;
    beat_t             push_beat, head;

    sw_rx_framer #(.CNT_W(CNT_W)) u_framer (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .link_i       (link_i),
        .en_i         (rx_en_i),
        .tx_busy_i    (tx_busy_i),
        .start_ack_i  (start_ack_i),
        .pad_len_i    (pad_len_i),
        .bit_len_i    (bit_len_i),
        .accept_len_i (accept_len_i),
        .byte_vld_o   (byte_vld),
        .byte_o       (byte_val),
        .byte_ack_o   (byte_ack),
        .frame_end_o  (frame_end),
        .abort_o      (abort),
        .busy_o       (rx_busy_o),
        .ack_armed_o  (ack_armed)
    );

    sw_rx_tail u_tail (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .byte_vld_i  (byte_vld),
        .byte_i      (byte_val),
        .byte_ack_i  (byte_ack),
        .frame_end_i (frame_end),
        .abort_i     (abort),
        .push_o      (push),
        .beat_o      (push_beat)
    );

    sw_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (push),
        .beat_i  (push_beat),
        .pop_i   (m_tready_i),
        .valid_o (m_tvalid_o),
        .beat_o  (head)
    );

    assign m_tdata_o = head.data;
    assign m_tlast_o = head.last;
    assign m_tkeep_o = 1'b1;
    assign m_tuser_o = '0;

endmodule

// File: rtl/sw_link_rx_chk.sv
module sw_link_rx_chk #(
    parameter int USER_W = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tx_busy_i,
    input logic              start_ack_i,
    input logic              m_tvalid_o,
    input logic              m_tready_i,
    input logic [7:0]        m_tdata_o,
    input logic              m_tlast_o,
    input logic              m_tkeep_o,
    input logic [USER_W-1:0] m_tuser_o,
    input logic              rx_busy_o,
    input logic              ack_armed
);

    // R10: sideband constants on every valid beat
    a_r10_keep_user: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_tvalid_o |-> (m_tkeep_o && m_tuser_o == '0));

    // R9: a stalled beat stays put
    a_r9_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_tvalid_o && !m_tready_i) |=> (m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o)));

    // R8: the buffer only fills from an active reception
    a_r8_fill_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(m_tvalid_o) |-> $past(rx_busy_o));

    // R2: a busy transmitter keeps an unarmed receiver idle
    a_r2_tx_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rx_busy_o && !ack_armed && !start_ack_i && tx_busy_i) |=> !rx_busy_o);

    // R7: the arming flag only survives an idle period or a reception
    a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rx_busy_o) |-> !ack_armed);

endmodule

bind sw_link_rx sw_link_rx_chk #(.USER_W(USER_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_busy_i   (tx_busy_i),
    .start_ack_i (start_ack_i),
    .m_tvalid_o  (m_tvalid_o),
    .m_tready_i  (m_tready_i),
    .m_tdata_o   (m_tdata_o),
    .m_tlast_o   (m_tlast_o),
    .m_tkeep_o   (m_tkeep_o),
    .m_tuser_o   (m_tuser_o),
    .rx_busy_o   (rx_busy_o),
    .ack_armed   (u_framer.ack_armed_o)
);

// File: tb/tb_sw_link_rx.sv
module tb_sw_link_rx;

    localparam int DEPTH = 2;
    localparam int CW    = 12;
    localparam int P     = 20;
    localparam int B     = 8;
    localparam int A     = 6;
    localparam int H     = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       link = 1'b0, en = 1'b0, txb = 1'b0, sack = 1'b0, tready = 1'b0;
    logic       tvalid, tlast, tkeep, busy;
    logic [7:0] tdata;
    logic [1:0] tuser;

    sw_link_rx #(.DEPTH(DEPTH), .CNT_W(CW), .USER_W(2)) dut (
        .clk_i(clk), .rst_ni(rst_n), .link_i(link), .rx_en_i(en),
        .tx_busy_i(txb), .start_ack_i(sack),
        .pad_len_i(CW'(P)), .bit_len_i(CW'(B)), .accept_len_i(CW'(A)),
        .m_tvalid_o(tvalid), .m_tready_i(tready), .m_tdata_o(tdata),
        .m_tlast_o(tlast), .m_tkeep_o(tkeep), .m_tuser_o(tuser),
        .rx_busy_o(busy)
    );

    bit         wv[$], rq[$], bq[$], aq[$];
    int         evc[$];
    logic [8:0] evb[$];
    logic [8:0] mq[$];
    int         nvec = 0, nfail = 0, rmode = 1;
    string      tag = "R1";
    bit         done = 1'b0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic put(input bit v, input int n);
        for (int k = 0; k < n; k++) begin
            wv.push_back(v);
            rq.push_back(rmode == 1 || (rmode == 2 && (wv.size() % 2) == 0));
            bq.push_back(1'b0);
            aq.push_back(1'b0);
        end
    endtask

    task automatic busy_rng(input int a, input int b);
        for (int k = a; k <= b; k++) bq[k] = 1'b1;
    endtask

    task automatic ev(input int c, input bit l, input logic [7:0] dv);
        evc.push_back(c);
        evb.push_back({l, dv});
    endtask

    // pad of h high cycles, then the low slot and eight data slots, LSB first
    task automatic sendbyte(input logic [7:0] dv, input int h, output int f);
        put(1'b1, h);
        f = wv.size();
        put(1'b0, B);
        for (int k = 0; k < 8; k++) put(dv[k], B);
    endtask

    task automatic frame(input logic [7:0] bs[$], input int h, input bit live);
        int s, f, fl;
        put(1'b0, 4);
        s = wv.size();
        for (int p = 0; p < 2; p++) begin
            put(1'b1, h);
            put(1'b0, B);
        end
        fl = 0;
        for (int j = 0; j < bs.size(); j++) begin
            sendbyte(bs[j], h, f);
            if (live && j > 0) ev(f + 9*B - 1, 1'b0, bs[j-1]);
            fl = f;
        end
        if (live) begin
            ev(fl + 9*B + P - 1, 1'b1, bs[bs.size()-1]);
            busy_rng(s + 1, fl + 9*B + P - 1);
        end
        put(1'b0, P + 4);
    endtask

    task automatic run();
        for (int i = 0; i < wv.size(); i++) begin
            int sz;
            @(negedge clk);
            link   = wv[i];
            tready = rq[i];
            sack   = aq[i];
            chk(tvalid == (mq.size() > 0), "tvalid (R9)", int'(tvalid), int'(mq.size() > 0));
            if (tvalid && mq.size() > 0) begin
                chk(tdata == mq[0][7:0], "tdata (R4)", int'(tdata), int'(mq[0][7:0]));
                chk(tlast == mq[0][8], "tlast (R5)", int'(tlast), int'(mq[0][8]));
                chk(tkeep == 1'b1 && tuser == 2'b00, "keep/user (R10)", int'({tkeep, tuser}), 4);
            end
            chk(busy == bq[i], "rx_busy (R8)", int'(busy), int'(bq[i]));
            @(posedge clk);
            sz = mq.size();
            if (rq[i] && sz > 0) void'(mq.pop_front());
            if (evc.size() > 0 && evc[0] == i) begin
                if (sz < DEPTH) mq.push_back(evb[0]);
                void'(evc.pop_front());
                void'(evb.pop_front());
            end
        end
        wv.delete(); rq.delete(); bq.delete(); aq.delete();
        evc.delete(); evb.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog (R1): got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int s, f, a;
        repeat (3) @(negedge clk);
        tag = "R1";
        chk(tvalid == 1'b0, "tvalid in reset", int'(tvalid), 0);
        chk(busy == 1'b0, "busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tvalid == 1'b0 && busy == 1'b0, "idle after reset", int'({tvalid, busy}), 0);

        // R3 R4 R5: three-byte frame, LSB-first decode, TLAST on the last byte
        tag = "R3/R4/R5"; en = 1'b1; rmode = 1;
        frame('{8'h01, 8'h8E, 8'h72}, H, 1'b1);
        run();

        // R3: pad at exactly the acceptance length counts
        tag = "R3 exact";
        frame('{8'hF0, 8'h01}, A, 1'b1);
        run();

        // R3: short opening pad is rejected, nothing emitted
        tag = "R3 short";
        put(1'b0, 4); s = wv.size();
        put(1'b1, A - 1);
        busy_rng(s + 1, s + A - 1);
        put(1'b0, P + 4);
        run();

        // R6: short pad after a byte cancels the frame without a beat
        tag = "R6";
        put(1'b0, 4); s = wv.size();
        for (int p = 0; p < 2; p++) begin put(1'b1, H); put(1'b0, B); end
        sendbyte(8'h8E, H, f);
        put(1'b1, A - 1);
        busy_rng(s + 1, wv.size());
        put(1'b0, P + 4);
        run();

        // R2: disabled, then transmitter busy
        tag = "R2 disabled"; en = 1'b0;
        frame('{8'h72}, H, 1'b0);
        run();
        tag = "R2 tx busy"; en = 1'b1; txb = 1'b1;
        frame('{8'h72}, H, 1'b0);
        run();

        // R7: armed acknowledgement byte with enable low, then disarmed
        tag = "R7"; en = 1'b0; txb = 1'b1;
        put(1'b0, 2); a = wv.size(); put(1'b0, 2);
        aq[a] = 1'b1;
        s = wv.size();
        sendbyte(8'h72, H, f);
        ev(f + 9*B - 1, 1'b1, 8'h72);
        busy_rng(s + 1, f + 9*B - 1);
        put(1'b0, P + 4);
        sendbyte(8'h8E, H, f);
        put(1'b0, P + 4);
        run();
        txb = 1'b0; en = 1'b1;

        // R9: toggling ready
        tag = "R9 backpressure"; rmode = 2;
        frame('{8'hF0, 8'h01, 8'h8E}, H, 1'b1);
        run();

        // R9: buffer full drops later bytes, link keeps running
        tag = "R9 overflow"; rmode = 0;
        frame('{8'h01, 8'h8E, 8'h72, 8'hF0}, H, 1'b1);
        rmode = 1;
        put(1'b0, 8);
        run();

        // R5: recovery after drops with a fresh frame
        tag = "R5 recovery";
        frame('{8'h8E}, H, 1'b1);
        run();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule